// File: doc/BRIEF.md
# Packed Lane Width Converter

This unit reshapes 64-bit packed operands between lane widths. A narrowing ("pack") operation takes the lanes of two sources, squeezes each lane to half its width with saturation, and concatenates the two narrowed halves into one 64-bit result. A widening-style ("unpack") operation interleaves lanes drawn from matching halves of the two sources, at byte, 16-bit or 32-bit granularity.

Interleaving with an all-zero second source zero-extends narrow lanes to double width. Chaining byte and 16-bit interleaves over four 8-byte rows transposes a 4x8 byte matrix. Both uses come from the ordinary unpack path, with no extra hardware. The unit accepts one operation per cycle and returns its result one clock later.

Top module: `pack_unpack_unit`

## Requirements
- R1: While reset is asserted and after its release until the first accepted operation, `out_valid` is 0 and `result` is all zeros.
- R2: An operation presented with `in_valid`=1 at a rising edge produces its `result` with `out_valid`=1 after that edge. Back-to-back operations give back-to-back results. With `in_valid`=0, `out_valid` drops to 0 and `result` holds its last value.
- R3: `op`=0, `gran`=1 (signed pack, 16→8): each signed 16-bit lane is clamped to [-128,127]. The four lanes of `src_a` fill result bytes 0..3 and the four lanes of `src_b` fill bytes 4..7, in lane order.
- R4: `op`=0, `gran`=2 (signed pack, 32→16): each signed 32-bit lane is clamped to [-32768,32767]. The two lanes of `src_a` fill result halfwords 0..1 and the two lanes of `src_b` fill halfwords 2..3.
- R5: `op`=1 (unsigned pack, 16→8) ignores `gran` unless `gran`=3. Each signed 16-bit lane maps to 0 when negative, to 255 when above 255, and otherwise to its low byte. The `src_a` lanes fill bytes 0..3 and the `src_b` lanes fill bytes 4..7.
- R6: `op`=2 (interleave low) with `gran` 0/1/2 selects lane widths of 8/16/32 bits. Result lane 2k is lane k of `src_a` and result lane 2k+1 is lane k of `src_b`, for k over the lower half of the lanes.
- R7: `op`=3 (interleave high) follows the same pattern as R6, but lane k is taken from the upper half of each source: lane k+N/2 for N lanes.
- R8: The unsupported combinations `gran`=3 with any `op`, and `op`=0 with `gran`=0, give an all-zero result, still with `out_valid`=1.
- R9: Byte interleave-low with `src_b`=0 zero-extends the four low bytes of `src_a` into four 16-bit lanes.
- R10: Byte interleaves (low and high) of rows 0/1 and rows 2/3 of a 4x8 byte matrix, followed by 16-bit interleaves (low and high) of those results, yield the four 8-byte rows of its transpose.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operation present this cycle |
| op | input | 2 | 0 signed pack, 1 unsigned pack, 2 interleave low, 3 interleave high |
| gran | input | 2 | Lane width select: 0 byte, 1 16-bit, 2 32-bit, 3 unsupported |
| src_a | input | 64 | First operand |
| src_b | input | 64 | Second operand |
| out_valid | output | 1 | Result valid |
| result | output | 64 | Converted 64-bit result |

## Verification
The only state is the output register and its valid flag, so any corrupt internal state appears on `result` or `out_valid` in the cycle right after the operation that caused it. A stale or wrongly held register shows on the first idle cycle, as a change of `result` or a high `out_valid`. A wrong lane mapping or a wrong clamp shows as a mismatched byte in the very next result. Swapped halves, off-by-one lane indexing and saturation thresholds are therefore each exposed by a single operation with boundary values such as 127/128, -128/-129 and 255/256.

// File: rtl/pack_unpack_unit.sv
module pack_unpack_unit (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_valid,
  input  logic [1:0]  op,
  input  logic [1:0]  gran,
  input  logic [63:0] src_a,
  input  logic [63:0] src_b,
  output logic        out_valid,
  output logic [63:0] result
);
  localparam int W = 64;

  function automatic logic [7:0] clamp_s8(input logic [15:0] v);
    if ($signed(v) > 16'sd127)       return 8'h7f;
    else if ($signed(v) < -16'sd128) return 8'h80;
    else                             return v[7:0];
  endfunction

  function automatic logic [7:0] clamp_u8(input logic [15:0] v);
    if (v[15])             return 8'h00;
    else if (v[14:8] != 0) return 8'hff;
    else                   return v[7:0];
  endfunction

  function automatic logic [15:0] clamp_s16(input logic [31:0] v);
    if ($signed(v) > 32'sd32767)       return 16'h7fff;
    else if ($signed(v) < -32'sd32768) return 16'h8000;
    else                               return v[15:0];
  endfunction

  logic [W-1:0] pk_sb, pk_sw, pk_ub;
  logic [W-1:0] il_b, il_w, il_d, nxt;
  logic         hi;

  assign hi = op[0];

  always_comb begin
    for (int i = 0; i < 4; i++) begin
      pk_sb[i*8 +: 8]      = clamp_s8(src_a[i*16 +: 16]);
      pk_sb[32 + i*8 +: 8] = clamp_s8(src_b[i*16 +: 16]);
      pk_ub[i*8 +: 8]      = clamp_u8(src_a[i*16 +: 16]);
      pk_ub[32 + i*8 +: 8] = clamp_u8(src_b[i*16 +: 16]);
    end
    for (int i = 0; i < 2; i++) begin
      pk_sw[i*16 +: 16]      = clamp_s16(src_a[i*32 +: 32]);
      pk_sw[32 + i*16 +: 16] = clamp_s16(src_b[i*32 +: 32]);
    end
  end

  always_comb begin
    for (int i = 0; i < 8; i++)
      il_b[i*8 +: 8] = i[0] ? src_b[((i/2) + (hi ? 4 : 0))*8 +: 8]
                            : src_a[((i/2) + (hi ? 4 : 0))*8 +: 8];
    for (int i = 0; i < 4; i++)
      il_w[i*16 +: 16] = i[0] ? src_b[((i/2) + (hi ? 2 : 0))*16 +: 16]
                              : src_a[((i/2) + (hi ? 2 : 0))*16 +: 16];
    il_d = hi ? {src_b[63:32], src_a[63:32]} : {src_b[31:0], src_a[31:0]};
  end

  always_comb begin
    nxt = '0;
    if (gran != 2'd3) begin
      unique case (op)
        2'd0: nxt = (gran == 2'd1) ? pk_sb : (gran == 2'd2) ? pk_sw : '0;
        2'd1: nxt = pk_ub;
        default: nxt = (gran == 2'd0) ? il_b : (gran == 2'd1) ? il_w : il_d;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      result    <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) result <= nxt;
    end
  end
endmodule

// File: rtl/pack_unpack_chk.sv
module pack_unpack_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        in_valid,
  input logic [1:0]  op,
  input logic [1:0]  gran,
  input logic [63:0] src_a,
  input logic [63:0] src_b,
  input logic        out_valid,
  input logic [63:0] result
);
  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid); // R2
  AST_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid); // R2
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(result)); // R2
  AST_SPACK_HI_CLAMP: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op == 2'd0 && gran == 2'd1 && $signed(src_a[15:0]) > 16'sd127)
    |=> result[7:0] == 8'h7f); // R3
  AST_SPACK_DW_LO_CLAMP: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op == 2'd0 && gran == 2'd2 && $signed(src_b[31:0]) < -32'sd32768)
    |=> result[47:32] == 16'h8000); // R4
  AST_UPACK_NEG_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op == 2'd1 && gran != 2'd3 && src_a[15])
    |=> result[7:0] == 8'h00); // R5
  AST_ILV_LO_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op == 2'd2 && gran == 2'd0)
    |=> result[15:0] == {$past(src_b[7:0]), $past(src_a[7:0])}); // R6
  AST_ILV_HI_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op == 2'd3 && gran == 2'd0)
    |=> result[63:48] == {$past(src_b[63:56]), $past(src_a[63:56])}); // R7
  AST_UNSUPPORTED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && (gran == 2'd3 || (op == 2'd0 && gran == 2'd0)))
    |=> result == 64'd0); // R8
endmodule

bind pack_unpack_unit pack_unpack_chk u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op(op), .gran(gran),
  .src_a(src_a), .src_b(src_b), .out_valid(out_valid), .result(result)
);

// File: tb/tb_pack_unpack_unit.sv
module tb_pack_unpack_unit;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        in_valid = 0;
  logic [1:0]  op = 0;
  logic [1:0]  gran = 0;
  logic [63:0] src_a = 0;
  logic [63:0] src_b = 0;
  logic        out_valid;
  logic [63:0] result;

  int checks = 0;
  int fails = 0;
  bit done = 0;
  logic [63:0] exp_q[$];
  string       tag_q[$];

  always #5 clk = ~clk;

  pack_unpack_unit dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op(op), .gran(gran),
    .src_a(src_a), .src_b(src_b), .out_valid(out_valid), .result(result)
  );

  function automatic logic [7:0] ref_s8(input int v);
    return (v > 127) ? 8'h7f : (v < -128) ? 8'h80 : v[7:0];
  endfunction
  function automatic logic [7:0] ref_u8(input int v);
    return (v < 0) ? 8'h00 : (v > 255) ? 8'hff : v[7:0];
  endfunction
  function automatic logic [15:0] ref_s16(input longint v);
    return (v > 32767) ? 16'h7fff : (v < -32768) ? 16'h8000 : v[15:0];
  endfunction

  function automatic logic [63:0] model(input logic [1:0] o, input logic [1:0] g,
                                        input logic [63:0] a, input logic [63:0] b);
    logic [63:0] r;
    logic [127:0] ab;
    int w, n;
    r = '0;
    ab = {b, a};
    if (g == 2'd3) return '0;
    if (o == 2'd0 && g == 2'd1 || o == 2'd1) begin
      for (int i = 0; i < 8; i++) begin
        int v;
        v = int'($signed(ab[i*16 +: 16]));
        r[i*8 +: 8] = (o == 2'd0) ? ref_s8(v) : ref_u8(v);
      end
    end else if (o == 2'd0 && g == 2'd2) begin
      for (int i = 0; i < 4; i++)
        r[i*16 +: 16] = ref_s16(longint'($signed(ab[i*32 +: 32])));
    end else if (o >= 2'd2) begin
      w = 8 << g;
      n = 64 / w;
      for (int i = 0; i < n; i++) begin
        int k;
        logic [63:0] s;
        k = i / 2 + ((o == 2'd3) ? n / 2 : 0);
        s = (i % 2 == 0) ? a : b;
        for (int bt = 0; bt < w; bt++) r[i*w + bt] = s[k*w + bt];
      end
    end
    return r;
  endfunction

  task automatic send(input logic [1:0] o, input logic [1:0] g, input logic [63:0] a,
                      input logic [63:0] b, input logic [63:0] expv, input string tag);
    @(negedge clk);
    in_valid = 1; op = o; gran = g; src_a = a; src_b = b;
    exp_q.push_back(expv);
    tag_q.push_back(tag);
  endtask

  task automatic sendm(input logic [1:0] o, input logic [1:0] g, input logic [63:0] a,
                       input logic [63:0] b, input string tag);
    send(o, g, a, b, model(o, g, a, b), tag);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 0;
    end
  endtask

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, expv);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && out_valid) begin
      if (exp_q.size() == 0) chk(0, "R2 unexpected out_valid", result, 64'hx);
      else begin
        logic [63:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        chk(result === e, t, result, e);
      end
    end
  end

  function automatic logic [63:0] row(input int r);
    logic [63:0] v;
    for (int j = 0; j < 8; j++) v[j*8 +: 8] = 8'(r * 8 + j);
    return v;
  endfunction

  function automatic logic [63:0] trow(input int c0);
    logic [63:0] v;
    for (int k = 0; k < 8; k++) v[k*8 +: 8] = 8'((k % 4) * 8 + c0 + k / 4);
    return v;
  endfunction

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [63:0] held, t01l, t23l, t01h, t23h;
    repeat (3) @(negedge clk);
    chk(out_valid === 1'b0, "R1 out_valid in reset", {63'd0, out_valid}, 64'd0);
    chk(result === 64'd0, "R1 result in reset", result, 64'd0);
    @(negedge clk) rst_n = 1;
    @(negedge clk);
    chk(out_valid === 1'b0 && result === 64'd0, "R1 after reset release", result, 64'd0);

    send(2'd0, 2'd1, 64'hff80_0005_0080_7fff - 64'h0 , 64'hffff_007f_ff7f_8000,
         64'hff_7f_80_80_80_05_7f_7f, "R3 signed pack 16->8");
    sendm(2'd0, 2'd1, 64'h1234_fedc_0000_ff81, 64'h007e_ff7e_0100_fe00, "R3 signed pack mixed");
    send(2'd0, 2'd2, 64'hfffe0000_00010000, 64'hffff8000_00001234,
         64'h8000_1234_8000_7fff, "R4 signed pack 32->16");
    send(2'd0, 2'd2, 64'h00007fff_ffff7fff, 64'h80000000_00008000,
         64'h8000_7fff_7fff_8000, "R4 signed pack boundaries");
    send(2'd1, 2'd1, 64'h0080_00ff_ffff_0100, 64'h8000_7fff_0000_00fe,
         64'h00_ff_00_fe_80_ff_00_ff, "R5 unsigned pack");
    send(2'd1, 2'd0, 64'h0080_00ff_ffff_0100, 64'h8000_7fff_0000_00fe,
         64'h00_ff_00_fe_80_ff_00_ff, "R5 unsigned pack gran 0 ignored");
    sendm(2'd1, 2'd2, 64'h0101_00ff_ff00_0001, 64'h0000_0100_00ff_8001, "R5 unsigned pack gran 2 ignored");
    send(2'd2, 2'd0, 64'h07060504_03020100, 64'h17161514_13121110,
         64'h13031202_11011000, "R6 interleave low bytes");
    sendm(2'd2, 2'd1, 64'h07060504_03020100, 64'h17161514_13121110, "R6 interleave low 16-bit");
    send(2'd2, 2'd2, 64'haaaaaaaa_11111111, 64'hbbbbbbbb_22222222,
         64'h22222222_11111111, "R6 interleave low 32-bit");
    send(2'd3, 2'd0, 64'h07060504_03020100, 64'h17161514_13121110,
         64'h17071606_15051404, "R7 interleave high bytes");
    sendm(2'd3, 2'd1, 64'h07060504_03020100, 64'h17161514_13121110, "R7 interleave high 16-bit");
    send(2'd3, 2'd2, 64'haaaaaaaa_11111111, 64'hbbbbbbbb_22222222,
         64'hbbbbbbbb_aaaaaaaa, "R7 interleave high 32-bit");
    send(2'd0, 2'd0, 64'h1234, 64'h5678, 64'd0, "R8 signed pack byte unsupported");
    send(2'd0, 2'd3, 64'h1234, 64'h5678, 64'd0, "R8 gran 3 op 0");
    send(2'd1, 2'd3, 64'h1234, 64'h5678, 64'd0, "R8 gran 3 op 1");
    send(2'd2, 2'd3, 64'h1234, 64'h5678, 64'd0, "R8 gran 3 op 2");
    send(2'd3, 2'd3, 64'h1234, 64'h5678, 64'd0, "R8 gran 3 op 3");
    send(2'd2, 2'd0, 64'h88776655_443322f1, 64'd0, 64'h0044_0033_0022_00f1, "R9 zero extend");

    t01l = model(2'd2, 2'd0, row(0), row(1));
    t23l = model(2'd2, 2'd0, row(2), row(3));
    t01h = model(2'd3, 2'd0, row(0), row(1));
    t23h = model(2'd3, 2'd0, row(2), row(3));
    sendm(2'd2, 2'd0, row(0), row(1), "R6 transpose step");
    sendm(2'd2, 2'd0, row(2), row(3), "R6 transpose step");
    send(2'd2, 2'd1, t01l, t23l, trow(0), "R10 transpose cols 0-1");
    send(2'd3, 2'd1, t01l, t23l, trow(2), "R10 transpose cols 2-3");
    send(2'd2, 2'd1, t01h, t23h, trow(4), "R10 transpose cols 4-5");
    send(2'd3, 2'd1, t01h, t23h, trow(6), "R10 transpose cols 6-7");

    idle(1);
    @(negedge clk);
    held = result;
    chk(out_valid === 1'b0, "R2 out_valid low when idle", {63'd0, out_valid}, 64'd0);
    idle(3);
    chk(result === held, "R2 result held when idle", result, held);
    chk(out_valid === 1'b0, "R2 out_valid stays low", {63'd0, out_valid}, 64'd0);
    chk(exp_q.size() == 0, "R2 all results returned", 64'(exp_q.size()), 64'd0);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule